// File: doc/BRIEF.md
# Processor-mode banked register file

This block stores the sixteen general registers of a processor core, together with the current status word and one saved status word for each privileged exception mode. Some registers have several physical copies, and the copy that a read or write reaches depends on the mode field of the current status word. In the fast-interrupt mode, registers 8 to 12 have their own copies. Registers 13 and 14 have a copy for each privileged mode and one copy that user and system modes share. Registers 0 to 7 and 15 have a single copy.

The execution unit reads through two combinational ports and writes through one clocked port. It changes mode by writing a new status word. After a mode change, every later access reaches the copies that belong to the new mode, so the old mode's values are preserved until that mode is entered again. Privileged code can raise a user-view input. A read or write made while it is high reaches the copies that user and system modes see, whatever the current mode. The status write port can also target the saved status word of the current mode. A live status write that carries an undefined mode encoding is rejected and flagged.

Top module: `banked_regfile`

## Requirements
- R1: After reset the live status word reads 0x0000001F (system mode), every register reads zero on both read ports, the saved status output is zero and `mode_err` is low.
- R2: Both read ports are combinational. A register write is visible one clock after it is presented. Registers 0 to 7 and 15 have one copy that every mode shares.
- R3: Registers 8 to 12 have two copies. Fast-interrupt mode (bits 4:0 = 10001) uses one copy, and every other mode uses the other.
- R4: Registers 13 and 14 have six copies: one for each of supervisor (10011), abort (10111), undefined (11011), interrupt (10010) and fast-interrupt (10001), and one that user (10000) and system (11111) share.
- R5: Each of the five privileged modes has its own saved status word. A status write with `sr_target_saved`=1 updates the current mode's saved word one clock later. In user or system mode `sr_saved` reads zero and such a write has no effect.
- R6: A live status write (`sr_target_saved`=0) with a legal mode encoding in bits 4:0 replaces the whole status word one clock later, and from then on accesses use the new mode's copies. The other fields (T bit 5, F bit 6, I bit 7, V/C/Z/N bits 28..31) are stored unchanged.
- R7: With `user_view`=1, registers 8 to 12 in fast-interrupt mode reach the non-fast-interrupt copy, and registers 13 and 14 in any privileged mode reach the user/system copy. All other accesses are unaffected. This applies to both reads and writes.
- R8: A live status write whose bits 4:0 are not one of the seven legal encodings leaves the status word and all copies unchanged, and `mode_err` is high for exactly the following cycle.
- R9: A register write presented in the same cycle as a mode-changing status write lands in the copy of the mode that was current before the change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_a_idx | input | 4 | Read port A register number |
| rd_a_data | output | W | Read port A data |
| rd_b_idx | input | 4 | Read port B register number |
| rd_b_data | output | W | Read port B data |
| wr_en | input | 1 | Register write enable |
| wr_idx | input | 4 | Register write number |
| wr_data | input | W | Register write data |
| user_view | input | 1 | Route reads and writes to user/system copies |
| sr_wr_en | input | 1 | Status write enable |
| sr_target_saved | input | 1 | 1: write the current mode's saved status; 0: write the live status |
| sr_wr_data | input | 32 | Status write data |
| sr_live | output | 32 | Current status word |
| sr_saved | output | 32 | Saved status word of the current mode (zero in user/system) |
| mode_err | output | 1 | Pulses for one cycle after a rejected status write |

## Verification
The bench uses the default width W=32. At that width register data fills the full word, and the status words carry their flag bits at 28..31 next to the mode field. Random status writes mix all seven legal modes with undefined encodings, and random register writes sometimes raise the user view. This makes every combination of old mode, new mode and banked register reachable, including fast-interrupt to and from the other modes and writes that land in the same cycle as a swap.

// File: rtl/banked_regfile.sv
module banked_regfile #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [3:0]   rd_a_idx,
  output logic [W-1:0] rd_a_data,
  input  logic [3:0]   rd_b_idx,
  output logic [W-1:0] rd_b_data,
  input  logic         wr_en,
  input  logic [3:0]   wr_idx,
  input  logic [W-1:0] wr_data,
  input  logic         user_view,
  input  logic         sr_wr_en,
  input  logic         sr_target_saved,
  input  logic [31:0]  sr_wr_data,
  output logic [31:0]  sr_live,
  output logic [31:0]  sr_saved,
  output logic         mode_err
);
  localparam logic [4:0] M_USR = 5'b10000;
  localparam logic [4:0] M_FIQ = 5'b10001;
  localparam logic [4:0] M_IRQ = 5'b10010;
  localparam logic [4:0] M_SVC = 5'b10011;
  localparam logic [4:0] M_ABT = 5'b10111;
  localparam logic [4:0] M_UND = 5'b11011;
  localparam logic [4:0] M_SYS = 5'b11111;
  localparam int NSP = 6;
  localparam int NSV = NSP - 1;

  logic [W-1:0] gen_q [0:7];
  logic [W-1:0] pc_q;
  logic [W-1:0] hi_q [0:1][0:4];
  logic [W-1:0] sp_q [0:NSP-1][0:1];
  logic [31:0]  sv_q [0:NSV-1];
  logic [31:0]  sr_q;
  logic         err_q;

  function automatic logic [2:0] bank_of(input logic [4:0] m);
    case (m)
      M_SVC:   return 3'd1;
      M_ABT:   return 3'd2;
      M_UND:   return 3'd3;
      M_IRQ:   return 3'd4;
      M_FIQ:   return 3'd5;
      default: return 3'd0;
    endcase
  endfunction

  function automatic logic legal(input logic [4:0] m);
    return m == M_USR || m == M_FIQ || m == M_IRQ || m == M_SVC ||
           m == M_ABT || m == M_UND || m == M_SYS;
  endfunction

  logic [2:0] cur_bank;
  logic       hi_sel;
  logic [2:0] sp_sel;

  assign cur_bank = bank_of(sr_q[4:0]);
  assign hi_sel   = (sr_q[4:0] == M_FIQ) && !user_view;
  assign sp_sel   = user_view ? 3'd0 : cur_bank;

  function automatic logic [W-1:0] pick(input logic [3:0] idx);
    if (idx == 4'd15)     return pc_q;
    else if (!idx[3])     return gen_q[idx[2:0]];
    else if (idx <= 4'd12) return hi_q[hi_sel][idx[2:0]];
    else                  return sp_q[sp_sel][idx[1]];
  endfunction

  assign rd_a_data = pick(rd_a_idx);
  assign rd_b_data = pick(rd_b_idx);
  assign sr_live   = sr_q;
  assign sr_saved  = (cur_bank == 3'd0) ? 32'd0 : sv_q[cur_bank - 3'd1];
  assign mode_err  = err_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 8; i++) gen_q[i] <= '0;
      for (int i = 0; i < 5; i++) begin
        hi_q[0][i] <= '0;
        hi_q[1][i] <= '0;
      end
      for (int i = 0; i < NSP; i++) begin
        sp_q[i][0] <= '0;
        sp_q[i][1] <= '0;
      end
      for (int i = 0; i < NSV; i++) sv_q[i] <= '0;
      pc_q  <= '0;
      sr_q  <= 32'h0000_001F;
      err_q <= 1'b0;
    end else begin
      err_q <= 1'b0;
      if (wr_en) begin
        if (wr_idx == 4'd15)       pc_q <= wr_data;
        else if (!wr_idx[3])       gen_q[wr_idx[2:0]] <= wr_data;
        else if (wr_idx <= 4'd12)  hi_q[hi_sel][wr_idx[2:0]] <= wr_data;
        else                       sp_q[sp_sel][wr_idx[1]] <= wr_data;
      end
      if (sr_wr_en) begin
        if (sr_target_saved) begin
          if (cur_bank != 3'd0) sv_q[cur_bank - 3'd1] <= sr_wr_data;
        end else if (legal(sr_wr_data[4:0])) begin
          sr_q <= sr_wr_data;
        end else begin
          err_q <= 1'b1;
        end
      end
    end
  end

  // R8: rejected mode leaves the status word alone and flags it
  a_r8_bad_mode_rejected: assert property (@(posedge clk) disable iff (!rst_n)
    sr_wr_en && !sr_target_saved && !legal(sr_wr_data[4:0])
    |=> mode_err && $stable(sr_live));

  // R6: a legal live write commits in full on the next cycle
  a_r6_live_commit: assert property (@(posedge clk) disable iff (!rst_n)
    sr_wr_en && !sr_target_saved && legal(sr_wr_data[4:0])
    |=> sr_live == $past(sr_wr_data) && !mode_err);

  // R6: the current mode is always a legal encoding
  a_r6_mode_legal: assert property (@(posedge clk) disable iff (!rst_n)
    legal(sr_live[4:0]));

  // R5: no saved status is visible in user or system mode
  a_r5_no_saved_unpriv: assert property (@(posedge clk) disable iff (!rst_n)
    (sr_live[4:0] == M_USR || sr_live[4:0] == M_SYS) |-> sr_saved == 32'd0);

  // R8: the error flag only follows a status write
  a_r8_err_cause: assert property (@(posedge clk) disable iff (!rst_n)
    !sr_wr_en |=> !mode_err);
endmodule

// File: tb/banked_regfile_test.sv
module banked_regfile_test;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [3:0]  rd_a_idx = 0, rd_b_idx = 0, wr_idx = 0;
  logic [31:0] rd_a_data, rd_b_data, wr_data = 0;
  logic        wr_en = 0, user_view = 0, sr_wr_en = 0, sr_target_saved = 0;
  logic [31:0] sr_wr_data = 0, sr_live, sr_saved;
  logic        mode_err;

  int checks = 0;
  int fails = 0;

  always #10 clk = ~clk;

  banked_regfile #(.W(32)) uut (
    .clk(clk), .rst_n(rst_n),
    .rd_a_idx(rd_a_idx), .rd_a_data(rd_a_data),
    .rd_b_idx(rd_b_idx), .rd_b_data(rd_b_data),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .user_view(user_view),
    .sr_wr_en(sr_wr_en), .sr_target_saved(sr_target_saved),
    .sr_wr_data(sr_wr_data), .sr_live(sr_live), .sr_saved(sr_saved),
    .mode_err(mode_err)
  );

  // reference model: live registers plus swapped-out banks
  logic [31:0] mr [16];
  logic [31:0] mcpsr, mspsr;
  logic [31:0] mb_hi [2][5];
  logic [31:0] mb_sp [6][2];
  logic [31:0] mb_sv [5];
  logic        merr;
  int          swaps = 0;

  function automatic int bidx(input logic [4:0] m);
    case (m)
      5'b10011: return 1;
      5'b10111: return 2;
      5'b11011: return 3;
      5'b10010: return 4;
      5'b10001: return 5;
      default:  return 0;
    endcase
  endfunction

  function automatic bit mlegal(input logic [4:0] m);
    return m == 5'b10000 || m == 5'b10001 || m == 5'b10010 || m == 5'b10011 ||
           m == 5'b10111 || m == 5'b11011 || m == 5'b11111;
  endfunction

  function automatic logic [31:0] mread(input logic [3:0] idx);
    if (user_view && bidx(mcpsr[4:0]) != 0) begin
      if (idx >= 8 && idx <= 12 && mcpsr[4:0] == 5'b10001) return mb_hi[0][idx-8];
      if (idx == 13 || idx == 14) return mb_sp[0][idx-13];
    end
    return mr[idx];
  endfunction

  task automatic mwrite(input logic [3:0] idx, input logic [31:0] d);
    if (user_view && bidx(mcpsr[4:0]) != 0 && idx >= 8 && idx <= 12 && mcpsr[4:0] == 5'b10001)
      mb_hi[0][idx-8] = d;
    else if (user_view && bidx(mcpsr[4:0]) != 0 && (idx == 13 || idx == 14))
      mb_sp[0][idx-13] = d;
    else
      mr[idx] = d;
  endtask

  task automatic mreset();
    for (int i = 0; i < 16; i++) mr[i] = 0;
    for (int i = 0; i < 5; i++) begin mb_hi[0][i] = 0; mb_hi[1][i] = 0; mb_sv[i] = 0; end
    for (int i = 0; i < 6; i++) begin mb_sp[i][0] = 0; mb_sp[i][1] = 0; end
    mcpsr = 32'h1F; mspsr = 0; merr = 0;
  endtask

  task automatic mclock();
    int ob, nb, of, nf;
    if (wr_en) mwrite(wr_idx, wr_data);
    merr = 0;
    if (sr_wr_en) begin
      if (sr_target_saved) begin
        if (bidx(mcpsr[4:0]) != 0) mspsr = sr_wr_data;
      end else if (!mlegal(sr_wr_data[4:0])) begin
        merr = 1;
      end else begin
        if (sr_wr_data[4:0] != mcpsr[4:0]) begin
          swaps++;
          ob = bidx(mcpsr[4:0]); nb = bidx(sr_wr_data[4:0]);
          of = (mcpsr[4:0] == 5'b10001); nf = (sr_wr_data[4:0] == 5'b10001);
          for (int i = 0; i < 5; i++) mb_hi[of][i] = mr[8+i];
          mb_sp[ob][0] = mr[13]; mb_sp[ob][1] = mr[14];
          if (ob != 0) mb_sv[ob-1] = mspsr;
          for (int i = 0; i < 5; i++) mr[8+i] = mb_hi[nf][i];
          mr[13] = mb_sp[nb][0]; mr[14] = mb_sp[nb][1];
          mspsr = (nb != 0) ? mb_sv[nb-1] : 32'd0;
        end
        mcpsr = sr_wr_data;
      end
    end
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h (t=%0t)", req, act, exp, $time);
    end
  endtask

  function automatic string rtag(input logic [3:0] idx);
    if (user_view && (idx >= 8 && idx != 15)) return "R7";
    if (idx >= 8 && idx <= 12) return "R3";
    if (idx == 13 || idx == 14) return "R4";
    return "R2";
  endfunction

  task automatic compare_all();
    check(rtag(rd_a_idx), rd_a_data, mread(rd_a_idx));
    check(rtag(rd_b_idx), rd_b_data, mread(rd_b_idx));
    check("R6", sr_live, mcpsr);
    check("R5", sr_saved, (bidx(mcpsr[4:0]) != 0) ? mspsr : 32'd0);
    check("R8", {31'd0, mode_err}, {31'd0, merr});
  endtask

  task automatic step();
    #2;
    compare_all();
    @(posedge clk);
    mclock();
    @(negedge clk);
    wr_en = 0; sr_wr_en = 0; sr_target_saved = 0; user_view = 0;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #3_000_000;
    checks++; fails++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    logic [4:0] modes [7];
    modes = '{5'b10000, 5'b10001, 5'b10010, 5'b10011, 5'b10111, 5'b11011, 5'b11111};
    mreset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;

    // R1: reset state on both ports
    for (int i = 0; i < 16; i++) begin
      rd_a_idx = i[3:0]; rd_b_idx = 4'(15 - i); #1;
      check("R1", rd_a_data, 0);
      check("R1", rd_b_data, 0);
    end
    check("R1", sr_live, 32'h1F);
    check("R1", sr_saved, 0);
    check("R1", {31'd0, mode_err}, 0);

    // R9: write r13 in system mode while switching to supervisor
    wr_en = 1; wr_idx = 13; wr_data = 32'hAAAA_0013;
    sr_wr_en = 1; sr_wr_data = 32'h0000_0013;
    step();
    rd_a_idx = 13; #1;
    check("R9", rd_a_data, 32'h0);
    sr_wr_en = 1; sr_wr_data = 32'hF000_00DF;
    step();
    rd_a_idx = 13; #1;
    check("R9", rd_a_data, 32'hAAAA_0013);
    check("R6", sr_live, 32'hF000_00DF);

    // R3: fast-interrupt r8 separate from shared r8
    wr_en = 1; wr_idx = 8; wr_data = 32'h1111_0008; step();
    sr_wr_en = 1; sr_wr_data = 32'h0000_0011; step();
    rd_a_idx = 8; #1;
    check("R3", rd_a_data, 0);
    user_view = 1; rd_a_idx = 8; #1;
    check("R7", rd_a_data, 32'h1111_0008);
    user_view = 0;

    // R5: saved status write in fast-interrupt mode
    sr_wr_en = 1; sr_target_saved = 1; sr_wr_data = 32'h8000_0010; step();
    #1 check("R5", sr_saved, 32'h8000_0010);

    // R8: undefined mode rejected
    sr_wr_en = 1; sr_wr_data = 32'h0000_0005; step();
    #1 check("R8", {31'd0, mode_err}, 1);
    check("R8", sr_live, 32'h0000_0011);

    // random traffic compared every cycle
    for (int n = 0; n < 6000; n++) begin
      int p;
      logic [31:0] d;
      rd_a_idx = 4'($urandom); rd_b_idx = 4'($urandom);
      wr_en = ($urandom % 2) == 0;
      wr_idx = 4'($urandom); wr_data = $urandom;
      if ($urandom % 3 == 0) wr_idx = 4'(8 + $urandom % 7);
      user_view = ($urandom % 4) == 0;
      sr_wr_en = ($urandom % 6) == 0;
      sr_target_saved = ($urandom % 4) == 0;
      p = $urandom % 9;
      d = $urandom;
      d[4:0] = (p < 7) ? modes[p] : 5'($urandom % 16);
      sr_wr_data = d;
      step();
    end
    check("R6", (swaps > 50) ? 32'd1 : 32'd0, 32'd1);
    finish_run();
  end
endmodule